// File: doc/BRIEF.md
# PHY Quick-Status Register with Interrupt

This block is the 16-bit quick-status register of one Ethernet physical-layer channel. It sits behind a management register port with a read strobe and a write strobe. Event and level inputs from the receive path, the link monitor and the autonegotiation engine feed it. Error conditions are held in sticky flags. Link status latches low. The lowest and highest autonegotiation states seen since the last read are tracked. Partner pause, speed and duplex pass straight through.

A read returns the register as it stands in that cycle, including any event that arrives in the same cycle. The read-clear takes effect on the following clock edge. An event that arrives in the read cycle is therefore both reported and kept for the next read.

Two writable configuration bits select the interrupt source and mask the interrupt output. The configuration bit also changes the meaning of bit 14: it is either a false-carrier flag or a link-change flag.

Top module: `phy_qstat`

## Requirements
- R1: Bits 15 (receive error), 13 (remote fault) and 12 (unlock/jabber) reset to 0. Once set, each stays set until a read, and a read with no new event clears it.
- R2: The receive-error event and the false-carrier event set their flags only while `speed100` is 1. Bit 12 is set by `unlockEvt` when `speed100` is 1 and by `jabberEvt` when `speed100` is 0.
- R3: Bit 11 reads 1 only while the link is up and no link failure has occurred since the last read. A one-cycle drop of `linkUp` keeps bit 11 at 0 until a read.
- R4: With bit 7 set to 1, bit 14 is a sticky link-change flag that sets when `linkUp` changes value. False-carrier events are then ignored.
- R5: With bit 7 set to 0 and bit 6 set to 0, `irqOut` is 1 while any of bits 15 to 12 is set or bit 11 is latched low.
- R6: With bit 7 set to 1 and bit 6 set to 0, `irqOut` follows only the link-change flag (bit 14). A receive-error flag does not raise it.
- R7: When bit 6 is 1, `irqOut` stays at 0. Bits 7 and 6 reset to 0 and read back the last value written.
- R8: Bits 10, 9 and 8 report `partnerPause`, `speed100` (1 = 100 Mb/s) and `fullDuplex` (1 = full) in the same cycle.
- R9: Bits 5:3 hold the smallest and bits 2:0 the largest 3-bit autonegotiation code (000 to 111) seen since the last read, including the read cycle. After a read, both restart from the current state.
- R10: An event that arrives in the read cycle is returned by that read and is still set for the next read.
- R11: A write changes only bits 7 and 6. Written values in all other bit positions are ignored.
- R12: `irqOut` is a level. It stays high until the read that clears its cause, and it drops in the cycle after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Register read strobe; clears on the next edge |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Write data; only bits 7 and 6 are used |
| rdData | output | 16 | Current register contents |
| rxErrEvt | input | 1 | Receive error event |
| falseCarrEvt | input | 1 | False carrier event |
| remFaultEvt | input | 1 | Remote fault event |
| unlockEvt | input | 1 | Descrambler lost lock event (100 Mb/s) |
| jabberEvt | input | 1 | Jabber event (10 Mb/s) |
| linkUp | input | 1 | Live link status |
| partnerPause | input | 1 | Partner pause ability |
| speed100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| fullDuplex | input | 1 | 1 = full duplex |
| anState | input | 3 | Current autonegotiation state code |
| irqOut | output | 1 | Level interrupt |

## Verification
A corrupted sticky flag or link latch shows up at the ports in two ways. First, the interrupt rises or falls one edge early or late. Second, the read after the event returns a wrong bit, and the second read returns a wrong value. A tracker that restarts at the wrong point returns the wrong minimum or maximum on the first read after a sequence of states. Configuration corruption shows up as the wrong bit 7 or 6 on the next read, or as an interrupt that fires under the wrong source.

// File: rtl/phy_qstat_pkg.sv
package phy_qstat_pkg;
  localparam int DATA_W = 16;
  localparam int AN_W   = 3;
  localparam int NUM_STICKY = 4;  // bits 15..12

  typedef struct packed {
    logic clearOnRead;
    logic loadCfg;
    logic linkChgMode;
  } ctlStrobeT;
endpackage

// File: rtl/qstat_an_track.sv
module qstat_an_track #(
  parameter int AN_W = 3,
  parameter bit TRACK_MAX = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            restart,
  input  logic [AN_W-1:0] anState,
  output logic [AN_W-1:0] view
);
  localparam logic [AN_W-1:0] RESET_VAL = TRACK_MAX ? '0 : '1;

  logic [AN_W-1:0] trackQ;
  logic            takeNew;

  assign takeNew = TRACK_MAX ? (anState > trackQ) : (anState < trackQ);
  assign view    = takeNew ? anState : trackQ;

  always_ff @(posedge clk) begin
    if (!rstN)        trackQ <= RESET_VAL;
    else if (restart) trackQ <= anState;
    else              trackQ <= view;
  end

  generate
    if (TRACK_MAX) begin : g_maxChk
      // R9
      max_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
        !restart |=> (trackQ >= $past(trackQ)));
    end else begin : g_minChk
      // R9
      min_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
        !restart |=> (trackQ <= $past(trackQ)));
    end
  endgenerate
endmodule

// File: rtl/qstat_ctrl.sv
module qstat_ctrl
  import phy_qstat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_STICKY-1:0] flagQ,
  input  logic                  linkLatchQ,
  output ctlStrobeT             strobes,
  output logic                  intConf,
  output logic                  intMask,
  output logic                  irqOut
);
  localparam int CONF_BIT = 7;
  localparam int MASK_BIT = 6;
  localparam int CHG_IDX  = 2;  // bit 14 inside flagQ

  logic irqCause;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intConf <= 1'b0;
      intMask <= 1'b0;
    end else if (strobes.loadCfg) begin
      intConf <= wrData[CONF_BIT];
      intMask <= wrData[MASK_BIT];
    end
  end

  always_comb begin
    strobes.clearOnRead = rdEn;
    strobes.loadCfg     = wrEn;
    strobes.linkChgMode = intConf;
  end

  assign irqCause = intConf ? flagQ[CHG_IDX] : ((|flagQ) || !linkLatchQ);
  assign irqOut   = !intMask && irqCause;

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable({intConf, intMask}));
endmodule

// File: rtl/qstat_datapath.sv
module qstat_datapath
  import phy_qstat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobeT             strobes,
  input  logic                  intConf,
  input  logic                  intMask,
  input  logic                  rxErrEvt,
  input  logic                  falseCarrEvt,
  input  logic                  remFaultEvt,
  input  logic                  unlockEvt,
  input  logic                  jabberEvt,
  input  logic                  linkUp,
  input  logic                  partnerPause,
  input  logic                  speed100,
  input  logic                  fullDuplex,
  input  logic [AN_W-1:0]       anState,
  output logic [NUM_STICKY-1:0] flagQ,
  output logic                  linkLatchQ,
  output logic [DATA_W-1:0]     rdData
);
  logic [NUM_STICKY-1:0] evtVec;
  logic [NUM_STICKY-1:0] flagView;
  logic                  linkPrevQ;
  logic                  linkView;
  logic [1:0][AN_W-1:0]  anView;

  always_comb begin
    evtVec[3] = rxErrEvt && speed100;
    evtVec[2] = strobes.linkChgMode ? (linkUp ^ linkPrevQ) : (falseCarrEvt && speed100);
    evtVec[1] = remFaultEvt;
    evtVec[0] = speed100 ? unlockEvt : jabberEvt;
  end

  assign flagView = flagQ | evtVec;
  assign linkView = linkLatchQ && linkUp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ      <= '0;
      linkLatchQ <= 1'b1;
      linkPrevQ  <= 1'b0;
    end else begin
      flagQ      <= strobes.clearOnRead ? evtVec : flagView;
      linkLatchQ <= strobes.clearOnRead ? linkUp : linkView;
      linkPrevQ  <= linkUp;
    end
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_track
      qstat_an_track #(.AN_W(AN_W), .TRACK_MAX(g == 1)) u_track (
        .clk     (clk),
        .rstN    (rstN),
        .restart (strobes.clearOnRead),
        .anState (anState),
        .view    (anView[g])
      );
    end
  endgenerate

  assign rdData = {flagView, linkView, partnerPause, speed100, fullDuplex,
                   intConf, intMask, anView[0], anView[1]};

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearOnRead |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R3
  link_latch_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clearOnRead && !linkLatchQ) |=> !linkLatchQ);
endmodule

// File: rtl/phy_qstat.sv
module phy_qstat
  import phy_qstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxErrEvt,
  input  logic              falseCarrEvt,
  input  logic              remFaultEvt,
  input  logic              unlockEvt,
  input  logic              jabberEvt,
  input  logic              linkUp,
  input  logic              partnerPause,
  input  logic              speed100,
  input  logic              fullDuplex,
  input  logic [AN_W-1:0]   anState,
  output logic              irqOut
);
  ctlStrobeT             strobes;
  logic                  intConf;
  logic                  intMask;
  logic [NUM_STICKY-1:0] flagQ;
  logic                  linkLatchQ;

  qstat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdEn       (rdEn),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .flagQ      (flagQ),
    .linkLatchQ (linkLatchQ),
    .strobes    (strobes),
    .intConf    (intConf),
    .intMask    (intMask),
    .irqOut     (irqOut)
  );

  qstat_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .intConf      (intConf),
    .intMask      (intMask),
    .rxErrEvt     (rxErrEvt),
    .falseCarrEvt (falseCarrEvt),
    .remFaultEvt  (remFaultEvt),
    .unlockEvt    (unlockEvt),
    .jabberEvt    (jabberEvt),
    .linkUp       (linkUp),
    .partnerPause (partnerPause),
    .speed100     (speed100),
    .fullDuplex   (fullDuplex),
    .anState      (anState),
    .flagQ        (flagQ),
    .linkLatchQ   (linkLatchQ),
    .rdData       (rdData)
  );
endmodule

// File: tb/tb_phy_qstat.sv
module tb_phy_qstat;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic rxErrEvt = 0, falseCarrEvt = 0, remFaultEvt = 0, unlockEvt = 0, jabberEvt = 0;
  logic linkUp = 1, partnerPause = 0, speed100 = 1, fullDuplex = 0;
  logic [2:0] anState = 3'd0;
  logic irqOut;
  int nVec = 0, nBad = 0;
  logic [15:0] v;

  always #2 clk = ~clk;

  phy_qstat dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp,
                     input logic [15:0] mask);
    nVec++;
    if ((act & mask) !== (exp & mask)) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h (mask %h)", req, act & mask, exp & mask, mask);
    end
  endtask

  task automatic chkIrq(input string req, input logic exp);
    chk(req, {15'd0, irqOut}, {15'd0, exp}, 16'h0001);
  endtask

  task automatic doRead(output logic [15:0] val);
    @(negedge clk); rdEn = 1'b1;
    #1 val = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic doWrite(input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic t_reset;
    #1 chk("R1 R7 reset value", rdData, 16'h0A00, 16'hFFFF);
    chkIrq("R5 reset irq", 1'b0);
  endtask

  task automatic t_sticky;
    rxErrEvt = 1; @(negedge clk); rxErrEvt = 0;
    chkIrq("R5 irq after rx error", 1'b1);
    repeat (3) @(negedge clk);
    chkIrq("R12 irq held", 1'b1);
    doRead(v);
    chk("R1 bit15 set", v, 16'h8000, 16'hF000);
    chkIrq("R12 irq drops after read", 1'b0);
    doRead(v);
    chk("R1 bit15 cleared", v, 16'h0000, 16'hF000);
    remFaultEvt = 1; unlockEvt = 1; @(negedge clk); remFaultEvt = 0; unlockEvt = 0;
    repeat (2) @(negedge clk);
    doRead(v);
    chk("R1 bits13/12 set", v, 16'h3000, 16'hF000);
    doRead(v);
    chk("R1 bits13/12 cleared", v, 16'h0000, 16'hF000);
  endtask

  task automatic t_speed;
    speed100 = 0;
    rxErrEvt = 1; falseCarrEvt = 1; unlockEvt = 1;
    @(negedge clk); rxErrEvt = 0; falseCarrEvt = 0; unlockEvt = 0;
    chkIrq("R2 no irq for 100M-only events at 10M", 1'b0);
    doRead(v);
    chk("R2 10M ignores rx err/false carrier/unlock", v, 16'h0000, 16'hF200);
    jabberEvt = 1; @(negedge clk); jabberEvt = 0;
    doRead(v);
    chk("R2 jabber sets bit12 at 10M", v, 16'h1000, 16'hF000);
    speed100 = 1;
    falseCarrEvt = 1; @(negedge clk); falseCarrEvt = 0;
    doRead(v);
    chk("R2 false carrier at 100M", v, 16'h4000, 16'hF000);
  endtask

  task automatic t_link;
    linkUp = 0; @(negedge clk); linkUp = 1;
    chkIrq("R5 irq on link low", 1'b1);
    repeat (2) @(negedge clk);
    doRead(v);
    chk("R3 bit11 latched low", v, 16'h0000, 16'h0800);
    chkIrq("R12 irq drops after link read", 1'b0);
    doRead(v);
    chk("R3 bit11 back high", v, 16'h0800, 16'h0800);
  endtask

  task automatic t_sameCycle;
    @(negedge clk); rdEn = 1; remFaultEvt = 1;
    #1 v = rdData;
    @(negedge clk); rdEn = 0; remFaultEvt = 0;
    chk("R10 same-cycle event visible", v, 16'h2000, 16'hF000);
    doRead(v);
    chk("R10 same-cycle event kept", v, 16'h2000, 16'hF000);
    doRead(v);
    chk("R10 then cleared", v, 16'h0000, 16'hF000);
  endtask

  task automatic t_an;
    anState = 3'd3;
    doRead(v);
    anState = 3'd5; @(negedge clk);
    anState = 3'd1; @(negedge clk);
    anState = 3'd4;
    doRead(v);
    chk("R9 low=1 high=5", v, 16'h000D, 16'h003F);
    doRead(v);
    chk("R9 restart from current", v, 16'h0024, 16'h003F);
    anState = 3'd0;
  endtask

  task automatic t_direct;
    partnerPause = 1; speed100 = 1; fullDuplex = 1;
    #1 chk("R8 pause/speed/duplex 1,1,1", rdData, 16'h0700, 16'h0700);
    partnerPause = 0; speed100 = 0; fullDuplex = 1;
    #1 chk("R8 pause/speed/duplex 0,0,1", rdData, 16'h0100, 16'h0700);
    speed100 = 1; fullDuplex = 0;
    @(negedge clk);
  endtask

  task automatic t_write;
    doWrite(16'hFFFF);
    doRead(v);
    chk("R11 only bits7/6 written", v, 16'h0AC0, 16'hFFC0);
    chkIrq("R7 masked after write", 1'b0);
    rxErrEvt = 1; @(negedge clk); rxErrEvt = 0;
    chkIrq("R7 mask suppresses irq", 1'b0);
    doRead(v);
    chk("R7 flag still records while masked", v, 16'h80C0, 16'h80C0);
    doWrite(16'h0000);
    doRead(v);
    chk("R7 cfg readback zero", v, 16'h0000, 16'h00C0);
  endtask

  task automatic t_mode1;
    doWrite(16'h0080);
    doRead(v);
    falseCarrEvt = 1; rxErrEvt = 1; @(negedge clk); falseCarrEvt = 0; rxErrEvt = 0;
    chkIrq("R6 rx error no irq in mode1", 1'b0);
    doRead(v);
    chk("R4 false carrier ignored in mode1", v, 16'h8080, 16'hC080);
    linkUp = 0; @(negedge clk); linkUp = 1; @(negedge clk);
    chkIrq("R6 irq on link change", 1'b1);
    doRead(v);
    chk("R4 link change flag and latch", v, 16'h4080, 16'h4880);
    chkIrq("R12 mode1 irq drops", 1'b0);
    doRead(v);
    chk("R4 change flag cleared", v, 16'h0880, 16'h4880);
    doWrite(16'h0000);
    doRead(v);
  endtask

  initial begin
    #(4 * 100000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_speed();
    t_link();
    t_sameCycle();
    t_an();
    t_direct();
    t_write();
    t_mode1();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule